// File: doc/BRIEF.md
# Input Capture Holding Latch

This block watches several timer input pins. A rising edge on a pin stores the present value of a free-running timer count in that pin's capture register. The same edge also adds one to the pin's 8-bit pulse accumulator. Each channel has a holding register for its capture value and another for its accumulator count.

A latch action copies every capture register and every accumulator into its holding register in a single clock edge, and clears the accumulators in that same edge. Software starts a latch by writing one to a command bit. Other logic can start one through a request input. In both cases the latch is allowed only when two configuration bits, latch mode and buffering, are both set.

Software reads the holding registers over a simple register bus. The bus has a write strobe, one address used for both reads and writes, write data, and combinational read data.

Top module: `cap_hold_latch`

## Requirements
- R1: After reset, reads of every holding register and of the configuration register (address 0) return zero.
- R2: A rising edge on `chan_in[i]` loads the value on `tmr_cnt` in that cycle into channel i's capture register. A later latch makes that value readable at address 2+i.
- R3: Each rising edge on `chan_in[i]` adds one to channel i's accumulator. At 255 the accumulator saturates and does not wrap. A later latch makes the count readable at address 2+NUM_CH+i.
- R4: A latch copies all capture registers and all accumulators into their holding registers in one clock edge.
- R5: A latch clears every accumulator to zero.
- R6: A latch happens only when configuration bit 0 (latch mode) and bit 1 (buffering) are both set. A latch request made while either bit is clear leaves every holding register and every accumulator unchanged.
- R7: A write to the command register (address 1) with bit 0 equal to 0 does nothing, whatever the other data bits hold.
- R8: Reads of the command register always return zero.
- R9: While both enable bits are set, a high `ext_latch_req` for one cycle performs the same latch as the command bit.
- R10: If a capture edge and a latch fall in the same cycle, the holding registers get the values from before the edge. The accumulator ends at zero, because the clear wins over the increment. The capture register still takes the new timer value.
- R11: Writes to holding-register addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address, used for both reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| chan_in | input | NUM_CH | Channel input pins |
| tmr_cnt | input | TS_W | Free-running timer count |
| ext_latch_req | input | 1 | Latch request from other logic |

## Verification
The hardest case to reach from the ports is a capture edge that lands in the very cycle a latch is requested. The bench produces it by driving the pin high, a new timer value and the command write all at the same falling clock edge. A second latch then exposes the post-edge capture value and the cleared count.

Saturation takes 300 pulses on one channel, so the channel must pass 255 before its count is latched. The gating cases are set up by giving the accumulators a nonzero count first, so that an illegal latch would show up as changed holding registers.

// File: rtl/cap_hold_latch_pkg.sv
package cap_hold_latch_pkg;
   localparam int OFS_CFG       = 0;
   localparam int OFS_CMD       = 1;
   localparam int OFS_HOLD_BASE = 2;
   localparam int CFG_LAT_BIT   = 0;
   localparam int CFG_BUF_BIT   = 1;
   localparam int CMD_FORCE_BIT = 0;

   typedef struct packed {
      logic buf_en;
      logic lat_mode;
   } chl_cfg_t;

   function automatic logic cfg_allows(chl_cfg_t c);
      return c.lat_mode & c.buf_en;
   endfunction
endpackage

// File: rtl/chl_edge_detect.sv
module chl_edge_detect #(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pin_i,
   output logic [NUM_CH-1:0] rise_o
);
   logic [NUM_CH-1:0] pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= '0;
      else        pin_q <= pin_i;
   end

   assign rise_o = pin_i & ~pin_q;
endmodule

// File: rtl/chl_channel.sv
module chl_channel #(
   parameter int TS_W     = 16,
   parameter int PA_W     = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rise_i,
   input  logic            clear_i,
   input  logic [TS_W-1:0] tmr_i,
   output logic [TS_W-1:0] cap_o,
   output logic [PA_W-1:0] acc_o
);
   localparam logic [PA_W-1:0] ACC_MAX = {PA_W{1'b1}};

   logic [PA_W-1:0] acc_inc;

   generate
      if (SATURATE) begin : g_sat
         assign acc_inc = (acc_o == ACC_MAX) ? acc_o : acc_o + 1'b1;
      end else begin : g_wrap
         assign acc_inc = acc_o + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_o <= '0;
      else if (rise_i) cap_o <= tmr_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_o <= '0;
      else if (clear_i) acc_o <= '0;
      else if (rise_i)  acc_o <= acc_inc;
   end
endmodule

// File: rtl/chl_hold_bank.sv
module chl_hold_bank #(
   parameter int NUM_CH = 4,
   parameter int TS_W   = 16,
   parameter int PA_W   = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_i,
   input  logic [NUM_CH*TS_W-1:0] cap_i,
   input  logic [NUM_CH*PA_W-1:0] acc_i,
   output logic [NUM_CH*TS_W-1:0] hcap_o,
   output logic [NUM_CH*PA_W-1:0] hacc_o
);
   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hcap_o[i*TS_W +: TS_W] <= '0;
               hacc_o[i*PA_W +: PA_W] <= '0;
            end else if (load_i) begin
               hcap_o[i*TS_W +: TS_W] <= cap_i[i*TS_W +: TS_W];
               hacc_o[i*PA_W +: PA_W] <= acc_i[i*PA_W +: PA_W];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/chl_regif.sv
module chl_regif
   import cap_hold_latch_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int TS_W   = 16,
   parameter int PA_W   = 8,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wr,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [DATA_W-1:0]      bus_wdata,
   output logic [DATA_W-1:0]      bus_rdata,
   input  logic                   ext_req_i,
   input  logic [NUM_CH*TS_W-1:0] hcap_i,
   input  logic [NUM_CH*PA_W-1:0] hacc_i,
   output chl_cfg_t               cfg_o,
   output logic                   latch_o
);
   localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFS_CMD);
   localparam int HCAP_BASE = OFS_HOLD_BASE;
   localparam int HACC_BASE = OFS_HOLD_BASE + NUM_CH;

   logic force_wr;
   logic unused_wdata;

   assign unused_wdata = ^bus_wdata[DATA_W-1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_o <= '0;
      else if (bus_wr && bus_addr == A_CFG) begin
         cfg_o.lat_mode <= bus_wdata[CFG_LAT_BIT];
         cfg_o.buf_en   <= bus_wdata[CFG_BUF_BIT];
      end
   end

   assign force_wr = bus_wr && (bus_addr == A_CMD) && bus_wdata[CMD_FORCE_BIT];
   assign latch_o  = (force_wr || ext_req_i) && cfg_allows(cfg_o);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CFG) begin
         bus_rdata[CFG_LAT_BIT] = cfg_o.lat_mode;
         bus_rdata[CFG_BUF_BIT] = cfg_o.buf_en;
      end
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr == ADDR_W'(HCAP_BASE + i))
            bus_rdata[TS_W-1:0] = hcap_i[i*TS_W +: TS_W];
         if (bus_addr == ADDR_W'(HACC_BASE + i))
            bus_rdata[PA_W-1:0] = hacc_i[i*PA_W +: PA_W];
      end
   end
endmodule

// File: rtl/cap_hold_latch.sv
module cap_hold_latch
   import cap_hold_latch_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int TS_W     = 16,
   parameter int PA_W     = 8,
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] chan_in,
   input  logic [TS_W-1:0]   tmr_cnt,
   input  logic              ext_latch_req
);
   localparam int REG_COUNT = OFS_HOLD_BASE + 2 * NUM_CH;

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("cap_hold_latch: NUM_CH must be at least 1");
      end
      if (REG_COUNT > (1 << ADDR_W)) begin : g_bad_addr
         $error("cap_hold_latch: ADDR_W too small for register map");
      end
      if (DATA_W < TS_W || DATA_W < PA_W || DATA_W < 3) begin : g_bad_data
         $error("cap_hold_latch: DATA_W too narrow");
      end
   endgenerate

   logic [NUM_CH-1:0]      rise_vec;
   logic [NUM_CH*TS_W-1:0] cap_flat;
   logic [NUM_CH*PA_W-1:0] acc_flat;
   logic [NUM_CH*TS_W-1:0] hcap_flat;
   logic [NUM_CH*PA_W-1:0] hacc_flat;
   logic                   latch_fire;
   chl_cfg_t               cfg;

   chl_edge_detect #(.NUM_CH(NUM_CH)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin_i(chan_in), .rise_o(rise_vec)
   );

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         chl_channel #(.TS_W(TS_W), .PA_W(PA_W), .SATURATE(SATURATE)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .rise_i(rise_vec[i]), .clear_i(latch_fire), .tmr_i(tmr_cnt),
            .cap_o(cap_flat[i*TS_W +: TS_W]), .acc_o(acc_flat[i*PA_W +: PA_W])
         );
      end
   endgenerate

   chl_hold_bank #(.NUM_CH(NUM_CH), .TS_W(TS_W), .PA_W(PA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .load_i(latch_fire),
      .cap_i(cap_flat), .acc_i(acc_flat),
      .hcap_o(hcap_flat), .hacc_o(hacc_flat)
   );

   chl_regif #(
      .NUM_CH(NUM_CH), .TS_W(TS_W), .PA_W(PA_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regif (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ext_req_i(ext_latch_req), .hcap_i(hcap_flat), .hacc_i(hacc_flat),
      .cfg_o(cfg), .latch_o(latch_fire)
   );
endmodule

// File: rtl/cap_hold_latch_chk.sv
module cap_hold_latch_chk #(
   parameter int NUM_CH = 4,
   parameter int TS_W   = 16,
   parameter int PA_W   = 8,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic [DATA_W-1:0]      bus_rdata,
   input logic [TS_W-1:0]        tmr_cnt,
   input logic                   ext_latch_req,
   input logic [NUM_CH-1:0]      rise_vec,
   input logic [NUM_CH*TS_W-1:0] cap_flat,
   input logic [NUM_CH*PA_W-1:0] acc_flat,
   input logic [NUM_CH*TS_W-1:0] hcap_flat,
   input logic [NUM_CH*PA_W-1:0] hacc_flat,
   input logic                   latch_fire,
   input logic                   cfg_lat,
   input logic                   cfg_buf
);
   localparam logic [PA_W-1:0] ACC_MAX = {PA_W{1'b1}};

   a_r4_hold_copy: assert property (@(posedge clk) disable iff (!rst_n)
      latch_fire |=> (hcap_flat == $past(cap_flat)) && (hacc_flat == $past(acc_flat)));

   a_r5_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      latch_fire |=> acc_flat == '0);

   a_r6_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_fire |=> $stable(hcap_flat) && $stable(hacc_flat));

   a_r6_gate: assert property (@(posedge clk) disable iff (!rst_n)
      latch_fire |-> cfg_lat && cfg_buf);

   a_r8_cmd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == ADDR_W'(1) |-> bus_rdata == '0);

   a_r9_ext_req: assert property (@(posedge clk) disable iff (!rst_n)
      ext_latch_req && cfg_lat && cfg_buf |-> latch_fire);

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
            rise_vec[i] |=> cap_flat[i*TS_W +: TS_W] == $past(tmr_cnt));

         a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_flat[i*PA_W +: PA_W] == ACC_MAX) && !latch_fire
            |=> acc_flat[i*PA_W +: PA_W] == ACC_MAX);
      end
   endgenerate
endmodule

bind cap_hold_latch cap_hold_latch_chk #(
   .NUM_CH(NUM_CH), .TS_W(TS_W), .PA_W(PA_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
   .tmr_cnt(tmr_cnt), .ext_latch_req(ext_latch_req), .rise_vec(rise_vec),
   .cap_flat(cap_flat), .acc_flat(acc_flat), .hcap_flat(hcap_flat),
   .hacc_flat(hacc_flat), .latch_fire(latch_fire),
   .cfg_lat(cfg.lat_mode), .cfg_buf(cfg.buf_en)
);

// File: tb/cap_hold_latch_tb_top.sv
module cap_hold_latch_tb_top;
   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [3:0]  chan_in = '0;
   logic [15:0] tmr_cnt = '0;
   logic        ext_latch_req = 1'b0;

   int tests = 0;
   int fails = 0;

   logic [15:0] m_cap  [NCH];
   logic [7:0]  m_acc  [NCH];
   logic [15:0] m_hcap [NCH];
   logic [7:0]  m_hacc [NCH];
   logic [1:0]  m_cfg;

   always #4 clk = ~clk;

   cap_hold_latch dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_in(chan_in),
      .tmr_cnt(tmr_cnt), .ext_latch_req(ext_latch_req)
   );

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(logic [3:0] a, output logic [15:0] v);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic wr(logic [3:0] a, logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   function automatic void model_latch();
      for (int i = 0; i < NCH; i++) begin
         m_hcap[i] = m_cap[i]; m_hacc[i] = m_acc[i]; m_acc[i] = '0;
      end
   endfunction

   task automatic set_cfg(logic [1:0] c);
      wr(4'd0, {14'd0, c});
      m_cfg = c;
   endtask

   task automatic pulse(int ch, logic [15:0] t);
      @(negedge clk);
      chan_in[ch] = 1'b1; tmr_cnt = t;
      @(negedge clk);
      chan_in[ch] = 1'b0;
      m_cap[ch] = t;
      if (m_acc[ch] != 8'hFF) m_acc[ch] = m_acc[ch] + 8'd1;
   endtask

   task automatic force_latch(logic [15:0] d);
      wr(4'd1, d);
      if (d[0] && m_cfg == 2'b11) model_latch();
   endtask

   task automatic check_holds(string req);
      logic [15:0] v;
      for (int i = 0; i < NCH; i++) begin
         rd(4'(2 + i), v);
         check({req, " hold capture"}, v, m_hcap[i]);
         rd(4'(2 + NCH + i), v);
         check({req, " hold count"}, v, {8'd0, m_hacc[i]});
      end
   endtask

   task automatic t_reset();
      logic [15:0] v;
      rd(4'd0, v);
      check("R1 cfg reset", v, 16'h0000);
      check_holds("R1");
   endtask

   task automatic t_capture_latch();
      set_cfg(2'b11);
      pulse(0, 16'h1234);
      pulse(1, 16'h2222);
      pulse(1, 16'h2345);
      pulse(2, 16'hABCD);
      pulse(3, 16'h0F0F); pulse(3, 16'h0F10); pulse(3, 16'hFFFF);
      force_latch(16'h0001);
      check_holds("R2 R3 R4");
      force_latch(16'h0001);
      check_holds("R5 accumulators cleared");
   endtask

   task automatic t_saturate();
      for (int k = 0; k < 300; k++) pulse(2, 16'(k));
      force_latch(16'h0001);
      check_holds("R3 saturation");
   endtask

   task automatic t_gating();
      pulse(1, 16'h5A5A);
      set_cfg(2'b01);
      force_latch(16'h0001);
      check_holds("R6 latch mode only");
      set_cfg(2'b10);
      force_latch(16'h0001);
      @(negedge clk); ext_latch_req = 1'b1;
      @(negedge clk); ext_latch_req = 1'b0;
      check_holds("R6 buffering only");
      set_cfg(2'b11);
      force_latch(16'h0001);
      check_holds("R6 enabled latch keeps count");
   endtask

   task automatic t_write_zero();
      logic [15:0] v;
      pulse(0, 16'h7777);
      force_latch(16'hFFFE);
      check_holds("R7 zero write ignored");
      rd(4'd1, v);
      check("R8 command reads zero", v, 16'h0000);
      force_latch(16'h0001);
      check_holds("R7 count survived");
      rd(4'd1, v);
      check("R8 command reads zero after latch", v, 16'h0000);
   endtask

   task automatic t_ext_req();
      pulse(3, 16'h3333);
      pulse(2, 16'h4444);
      @(negedge clk); ext_latch_req = 1'b1;
      @(negedge clk); ext_latch_req = 1'b0;
      model_latch();
      check_holds("R9 external request");
   endtask

   task automatic t_same_cycle();
      pulse(0, 16'h1111);
      pulse(0, 16'h2222);
      @(negedge clk);
      chan_in[0] = 1'b1; tmr_cnt = 16'h9999;
      bus_wr = 1'b1; bus_addr = 4'd1; bus_wdata = 16'h0001;
      @(negedge clk);
      chan_in[0] = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
      model_latch();
      m_cap[0] = 16'h9999;
      check_holds("R10 pre-edge values held");
      force_latch(16'h0001);
      check_holds("R10 clear beat increment");
   endtask

   task automatic t_readonly();
      pulse(1, 16'hCAFE);
      for (int a = 2; a < 2 + 2 * NCH; a++) wr(4'(a), 16'hBEEF);
      check_holds("R11 holds read-only");
   endtask

   initial begin
      #(200000 * 8);
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < NCH; i++) begin
         m_cap[i] = '0; m_acc[i] = '0; m_hcap[i] = '0; m_hacc[i] = '0;
      end
      m_cfg = 2'b00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_capture_latch();
      t_saturate();
      t_gating();
      t_write_zero();
      t_ext_req();
      t_same_cycle();
      t_readonly();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule